// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block decides whether a segment-register load or a far control transfer may proceed under the ring protection model. The caller supplies the current privilege level, the 16-bit selector of the target, the decoded fields of the target descriptor, and an operation code. The operation code selects one of three cases: a data-segment load, a direct far call or jump, or a far call through a gate. One cycle after a request strobe, the unit presents a verdict together with a done pulse. The verdict is either allow or fault. The unit also reports which kind of call gate the descriptor names, the privilege level that governs the access, and the table select and index fields of the selector.

The unit is checking logic only. It does not fetch descriptors from memory. It does not check limits or paging, and it does not run the stack and register switch of a ring transition. A small two-state machine registers the result. In state IDLE the unit waits; a strobe moves it to REPORT. While the strobe stays high the unit remains in REPORT, and when the strobe drops it returns to IDLE. The done output is high exactly while the machine is in REPORT.

Top module: `seg_priv_chk`

## Requirements
- R1: The requested level is selector bits [1:0]. `tbl_local` reports selector bit 2, where 1 means the local table. `tbl_index` reports selector bits [15:3]. All three are captured with the verdict.
- R2: For a data load and for a gate transfer, `eff_pl` is max(`cur_pl`, requested level). For a direct transfer, `eff_pl` is `cur_pl`.
- R3: A data load (op 2'b00) is allowed only when `desc_s`=1, `desc_present`=1 and `desc_dpl` >= the effective level.
- R4: A direct transfer (op 2'b01) to a non-conforming code segment (`desc_conf`=0) is allowed only when `desc_s`=1, `desc_present`=1, `desc_type[3]`=1 (code) and `desc_dpl` == `cur_pl`.
- R5: A direct transfer to a conforming code segment (`desc_conf`=1) is allowed only when `desc_s`=1, `desc_present`=1, `desc_type[3]`=1 and `desc_dpl` <= `cur_pl`. The reported level stays `cur_pl`.
- R6: A gate transfer (op 2'b10) is allowed only when `desc_s`=0, `desc_type` is 4'b0100 or 4'b1100, `desc_present`=1 and the effective level <= `desc_dpl`.
- R7: `gate_kind` is 2'b01 when `desc_s`=0 and the type is 4'b0100 (16-bit gate), 2'b10 when `desc_s`=0 and the type is 4'b1100 (32-bit gate), and 2'b00 otherwise, for any op.
- R8: A gate transfer naming a reserved type (0000, 1000, 1010, 1101), any other non-gate system type, a segment descriptor, or a non-present gate raises fault.
- R9: When done is high, exactly one of `allow` and `fault` is high. Op 2'b11 always gives fault.
- R10: `done` is high in the cycle after each clock edge that samples `req_valid`=1 and low otherwise. Back-to-back strobes keep it high. Without a strobe, all results hold their last values.
- R11: After reset, `done`, `allow`, `fault`, `gate_kind`, `eff_pl`, `tbl_local` and `tbl_index` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per check |
| req_op | input | 2 | 00 data load, 01 direct far transfer, 10 gate transfer, 11 unused |
| cur_pl | input | 2 | Current privilege level |
| selector | input | 16 | Target selector |
| desc_present | input | 1 | Descriptor present bit |
| desc_s | input | 1 | 1 for code/data segment, 0 for system entry |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_conf | input | 1 | Conforming code segment flag |
| done | output | 1 | Result valid pulse |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access refused |
| gate_kind | output | 2 | 00 none, 01 16-bit call gate, 10 32-bit call gate |
| eff_pl | output | 2 | Privilege level used by the check |
| tbl_local | output | 1 | Selector names the local table |
| tbl_index | output | 13 | Selector table index |

## Verification
The hardest case to reach is a refusal caused only by the requested level of the selector. Here the current level alone would pass the gate or data rule, and the weakened effective level fails it. The stimulus pairs a privileged `cur_pl` with a large selector RPL against a DPL that sits between the two. A second hard case is a stream of strobes with no gap, which keeps the machine in REPORT. The driver issues such a run, and the scoreboard must match each result in order with no idle cycle between them.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;

    localparam int TYPE_W = 4;

    typedef enum logic [1:0] {
        OP_DATA   = 2'b00,
        OP_DIRECT = 2'b01,
        OP_GATE   = 2'b10,
        OP_RSVD   = 2'b11
    } seg_op_e;

    typedef enum logic [1:0] {
        GK_NONE = 2'b00,
        GK_16   = 2'b01,
        GK_32   = 2'b10
    } gate_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } chk_state_e;

endpackage

// File: rtl/spc_sel_split.sv
module spc_sel_split #(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2,
    localparam int IDX_W = SEL_W - PL_W - 1
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [PL_W-1:0]  cur_pl,
    output logic [PL_W-1:0]  rpl,
    output logic             tbl_local,
    output logic [IDX_W-1:0] idx,
    output logic [PL_W-1:0]  eff_pl
);
    assign rpl       = sel[PL_W-1:0];
    assign tbl_local = sel[PL_W];
    assign idx       = sel[SEL_W-1:PL_W+1];
    // A larger number means less privilege; the weaker of the two wins.
    assign eff_pl    = (rpl > cur_pl) ? rpl : cur_pl;
endmodule

// File: rtl/spc_sys_decode.sv
module spc_sys_decode
    import seg_priv_pkg::*;
(
    input  logic              s_flag,
    input  logic [TYPE_W-1:0] type_code,
    output gate_kind_e        kind,
    output logic              is_call_gate,
    output logic              is_reserved
);
    always_comb begin
        kind        = GK_NONE;
        is_reserved = 1'b0;
        if (!s_flag) begin
            unique case (type_code)
                4'b0100: kind = GK_16;
                4'b1100: kind = GK_32;
                4'b0000, 4'b1000, 4'b1010, 4'b1101: is_reserved = 1'b1;
                default: kind = GK_NONE;
            endcase
        end
    end
    assign is_call_gate = (kind != GK_NONE);
endmodule

// File: rtl/spc_rule_eval.sv
module spc_rule_eval
    import seg_priv_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  seg_op_e         op,
    input  logic [PL_W-1:0] cur_pl,
    input  logic [PL_W-1:0] eff_in,
    input  logic            present,
    input  logic            s_flag,
    input  logic            code_seg,
    input  logic            conf,
    input  logic [PL_W-1:0] dpl,
    input  logic            call_gate,
    input  logic            rsvd_type,
    output logic            ok,
    output logic [PL_W-1:0] eff_out
);
    always_comb begin
        ok      = 1'b0;
        eff_out = eff_in;
        case (op)
            OP_DATA:   ok = s_flag && present && (dpl >= eff_in);
            OP_DIRECT: begin
                eff_out = cur_pl;
                ok = s_flag && present && code_seg &&
                     (conf ? (dpl <= cur_pl) : (dpl == cur_pl));
            end
            OP_GATE:   ok = !s_flag && call_gate && !rsvd_type && present &&
                            (eff_in <= dpl);
            default:   ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk
    import seg_priv_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int PL_W  = 2,
    localparam int IDX_W = SEL_W - PL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [PL_W-1:0]  cur_pl,
    input  logic [SEL_W-1:0] selector,
    input  logic             desc_present,
    input  logic             desc_s,
    input  logic [3:0]       desc_type,
    input  logic [PL_W-1:0]  desc_dpl,
    input  logic             desc_conf,
    output logic             done,
    output logic             allow,
    output logic             fault,
    output logic [1:0]       gate_kind,
    output logic [PL_W-1:0]  eff_pl,
    output logic             tbl_local,
    output logic [IDX_W-1:0] tbl_index
);
    logic [PL_W-1:0]  rpl_w, eff_w, eff_sel_w;
    logic             local_w, gate_w, rsvd_w, ok_w;
    logic [IDX_W-1:0] idx_w;
    gate_kind_e       kind_w;
    chk_state_e       state_q, state_d;
    seg_op_e          op_q;

    spc_sel_split #(.SEL_W(SEL_W), .PL_W(PL_W)) u_split (
        .sel(selector), .cur_pl(cur_pl), .rpl(rpl_w),
        .tbl_local(local_w), .idx(idx_w), .eff_pl(eff_w)
    );

    spc_sys_decode u_sys (
        .s_flag(desc_s), .type_code(desc_type), .kind(kind_w),
        .is_call_gate(gate_w), .is_reserved(rsvd_w)
    );

    spc_rule_eval #(.PL_W(PL_W)) u_rules (
        .op(seg_op_e'(req_op)), .cur_pl(cur_pl), .eff_in(eff_w),
        .present(desc_present), .s_flag(desc_s), .code_seg(desc_type[3]),
        .conf(desc_conf), .dpl(desc_dpl), .call_gate(gate_w),
        .rsvd_type(rsvd_w), .ok(ok_w), .eff_out(eff_sel_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!req_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            allow     <= 1'b0;
            fault     <= 1'b0;
            gate_kind <= GK_NONE;
            eff_pl    <= '0;
            tbl_local <= 1'b0;
            tbl_index <= '0;
            op_q      <= OP_DATA;
        end else if (req_valid) begin
            allow     <= ok_w;
            fault     <= !ok_w;
            gate_kind <= kind_w;
            eff_pl    <= eff_sel_w;
            tbl_local <= local_w;
            tbl_index <= idx_w;
            op_q      <= seg_op_e'(req_op);
        end
    end

    assign done = (state_q == ST_REPORT);

    // R9: a reported verdict is never both or neither
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({allow, fault}));

    // R10: every strobe yields a done in the next cycle
    p_strobe_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R10: no strobe, no done and no change of result
    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && $stable(allow) && $stable(fault) && $stable(eff_pl)));

    // R6: an allowed gate transfer always names a call gate
    p_gate_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && allow && op_q == OP_GATE) |-> (gate_kind != GK_NONE));

    // R9: the unused op code is never allowed
    p_rsvd_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_RSVD) |-> fault);
endmodule

// File: tb/test_seg_priv_chk.sv
module test_seg_priv_chk;

    typedef struct {
        logic        allow;
        logic        fault;
        logic [1:0]  kind;
        logic [1:0]  eff;
        logic        loc;
        logic [12:0] idx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [1:0]  cur_pl = '0;
    logic [15:0] selector = '0;
    logic        desc_present = 1'b0;
    logic        desc_s = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_conf = 1'b0;
    logic        done, allow, fault, tbl_local;
    logic [1:0]  gate_kind, eff_pl;
    logic [12:0] tbl_index;

    int total = 0;
    int bad = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    seg_priv_chk i_seg_priv_chk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .cur_pl(cur_pl), .selector(selector), .desc_present(desc_present),
        .desc_s(desc_s), .desc_type(desc_type), .desc_dpl(desc_dpl),
        .desc_conf(desc_conf), .done(done), .allow(allow), .fault(fault),
        .gate_kind(gate_kind), .eff_pl(eff_pl), .tbl_local(tbl_local),
        .tbl_index(tbl_index)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] op, input logic [1:0] cpl,
            input logic [15:0] sel, input logic p, input logic s,
            input logic [3:0] t, input logic [1:0] dpl, input logic conf,
            input string tag);
        exp_t e;
        logic [1:0] rq;
        logic [1:0] mx;
        logic ok;
        rq = sel[1:0];
        mx = (cpl > rq) ? cpl : rq;
        e.loc = sel[2];                 // R1
        e.idx = sel[15:3];              // R1
        e.kind = 2'b00;                 // R7
        if (!s && t == 4'b0100) e.kind = 2'b01;
        if (!s && t == 4'b1100) e.kind = 2'b10;
        ok = 1'b0;
        e.eff = mx;                     // R2
        if (op == 2'b00) ok = s && p && (dpl >= mx);                     // R3
        else if (op == 2'b01) begin
            e.eff = cpl;                                                 // R2, R5
            if (conf) ok = s && p && t[3] && (dpl <= cpl);               // R5
            else      ok = s && p && t[3] && (dpl == cpl);               // R4
        end else if (op == 2'b10)
            ok = !s && (t == 4'b0100 || t == 4'b1100) && p && (mx <= dpl); // R6, R8
        e.allow = ok;
        e.fault = !ok;                  // R9
        e.tag = tag;
        return e;
    endfunction

    // Driver: call at a falling edge; leaves the strobe high for one cycle.
    task automatic drive(input logic [1:0] op, input logic [1:0] cpl,
            input logic [15:0] sel, input logic p, input logic s,
            input logic [3:0] t, input logic [1:0] dpl, input logic conf,
            input string tag);
        req_op = op; cur_pl = cpl; selector = sel; desc_present = p;
        desc_s = s; desc_type = t; desc_dpl = dpl; desc_conf = conf;
        req_valid = 1'b1;
        sb.push_back(model(op, cpl, sel, p, s, t, dpl, conf, tag));
        @(negedge clk);
    endtask

    task automatic gap_and_hold(input string tag);
        logic a0, f0;
        logic [1:0] e0;
        req_valid = 1'b0;
        req_op = 2'b01; cur_pl = 2'b11; selector = 16'hFFFF;
        desc_dpl = 2'b00;
        @(negedge clk);
        a0 = allow; f0 = fault; e0 = eff_pl;
        @(negedge clk);
        check(done == 1'b0, tag, "done while idle", done, 0);
        check(allow == a0 && fault == f0 && eff_pl == e0, tag, "result hold",
              {allow, fault, eff_pl}, {a0, f0, e0});
    endtask

    // Monitor: compare each done cycle against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "done without request", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(allow == e.allow, e.tag, "allow", allow, e.allow);
                check(fault == e.fault, e.tag, "fault", fault, e.fault);
                check(gate_kind == e.kind, e.tag, "gate_kind", gate_kind, e.kind);
                check(eff_pl == e.eff, e.tag, "eff_pl", eff_pl, e.eff);
                check(tbl_local == e.loc, e.tag, "tbl_local", tbl_local, e.loc);
                check(tbl_index == e.idx, e.tag, "tbl_index", tbl_index, e.idx);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({done, allow, fault, gate_kind, eff_pl, tbl_local, tbl_index} == '0,
              "R11", "reset outputs",
              {done, allow, fault, gate_kind, eff_pl, tbl_local, tbl_index}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 data loads, R1 selector fields, R2 effective level
        drive(2'b00, 2'd0, 16'h0000, 1, 1, 4'b0010, 2'd0, 0, "R3");
        gap_and_hold("R10");
        drive(2'b00, 2'd1, 16'hABCF, 1, 1, 4'b0010, 2'd2, 0, "R2");
        drive(2'b00, 2'd2, 16'h1235, 1, 1, 4'b0010, 2'd3, 0, "R1");
        drive(2'b00, 2'd0, 16'h0008, 0, 1, 4'b0010, 2'd3, 0, "R3");
        drive(2'b00, 2'd0, 16'h0008, 1, 0, 4'b0010, 2'd3, 0, "R3");
        gap_and_hold("R10");
        // R4 non-conforming direct
        drive(2'b01, 2'd2, 16'h00F3, 1, 1, 4'b1010, 2'd2, 0, "R4");
        drive(2'b01, 2'd2, 16'h00F0, 1, 1, 4'b1010, 2'd1, 0, "R4");
        drive(2'b01, 2'd2, 16'h00F2, 1, 1, 4'b0010, 2'd2, 0, "R4");
        // R5 conforming direct
        drive(2'b01, 2'd3, 16'h7FF8, 1, 1, 4'b1110, 2'd0, 1, "R5");
        drive(2'b01, 2'd1, 16'h7FF8, 1, 1, 4'b1110, 2'd2, 1, "R5");
        drive(2'b01, 2'd1, 16'h7FFB, 0, 1, 4'b1110, 2'd1, 1, "R5");
        gap_and_hold("R10");
        // R6 gates, R7 kinds
        drive(2'b10, 2'd3, 16'h0140, 1, 0, 4'b1100, 2'd3, 0, "R6");
        drive(2'b10, 2'd0, 16'h0143, 1, 0, 4'b0100, 2'd2, 0, "R6");
        drive(2'b10, 2'd1, 16'h0141, 1, 0, 4'b0100, 2'd1, 0, "R7");
        drive(2'b10, 2'd0, 16'h0140, 0, 0, 4'b1100, 2'd3, 0, "R8");
        // R8 reserved and other system types
        drive(2'b10, 2'd0, 16'h0140, 1, 0, 4'b0000, 2'd3, 0, "R8");
        drive(2'b10, 2'd0, 16'h0140, 1, 0, 4'b1000, 2'd3, 0, "R8");
        drive(2'b10, 2'd0, 16'h0140, 1, 0, 4'b1010, 2'd3, 0, "R8");
        drive(2'b10, 2'd0, 16'h0140, 1, 0, 4'b1101, 2'd3, 0, "R8");
        drive(2'b10, 2'd0, 16'h0140, 1, 0, 4'b1001, 2'd3, 0, "R8");
        drive(2'b10, 2'd0, 16'h0140, 1, 1, 4'b1100, 2'd3, 0, "R8");
        // R7 gate kind reported for a non-gate op
        drive(2'b00, 2'd0, 16'h0140, 1, 0, 4'b1100, 2'd3, 0, "R7");
        // R9 unused op
        drive(2'b11, 2'd0, 16'h0000, 1, 1, 4'b0010, 2'd3, 0, "R9");
        gap_and_hold("R10");
        check(sb.size() == 0, "R10", "pending results", sb.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule